// File: doc/BRIEF.md
# Half-Duplex Link Register and Direction Control

This block is the processor-side control unit of a half-duplex asynchronous serial link that drives an external two-wire line transceiver. It decodes a 2-bit register address. The bus uses an active-low chip select and active-low write and read strobes. It keeps a one-bit direction request register and assembles a status byte from the flags that the serial engines report. It issues single-cycle enables to the transmit buffer and to the receive buffer. It also issues a single-cycle status-read pulse, which the receive engine uses to clear its error flag.

The block drives the line transceiver's driver enable (active high) and its receiver enable (active low) from a single internal direction state. The two pins therefore always move together. A requested direction change takes effect only when the engine that currently owns the line reports idle. A frame being sent or received is never cut off. The serial shifting is done elsewhere. This block only reads the idle, empty, full and error indications.

Top module: `hdx_link_ctrl`

## Requirements
- R1: After reset the unit is in transmit mode: `drv_en` = 1 and `rcv_en_n` = 1. All three enable pulses are 0, and the direction register holds 1.
- R2: A write to address 0 stores data bit 0 as the direction request (0 = receive, 1 = transmit). A read of address 0 returns that bit in bit 0, with bits 7..1 reading 0.
- R3: In transmit mode, if the direction request is 0 and `tx_idle` is 1 at a clock edge, then from that edge on `drv_en` and `rcv_en_n` are both 0. While `tx_idle` is 0 the mode does not change.
- R4: In receive mode, if the direction request is 1 and `rx_idle` is 1 at a clock edge, then from that edge on `drv_en` and `rcv_en_n` are both 1. While `rx_idle` is 0 the mode does not change.
- R5: A read of address 1 returns the status byte. Bit 0 is `tx_buf_empty`, bit 1 is `rx_buf_full`, bit 2 is `rx_frame_err`, and bits 7..3 are 0.
- R6: Each access raises `status_rd` for exactly one cycle, on the leading edge of a qualified read of address 1, no matter how long the strobe is held.
- R7: A read of address 3 returns `rx_buf_data`. On the leading edge of that read, `rx_buf_rd` pulses for exactly one cycle.
- R8: A write to address 2 in transmit mode raises `tx_buf_wr` for exactly one cycle, on the leading edge of the qualified write, even when the strobe is held.
- R9: A write to address 2 while in receive mode is ignored: `tx_buf_wr` stays 0.
- R10: With `cs_n` high, strobes have no effect. No pulse occurs, the direction register keeps its value, and `rdata` is 0. `rdata` is also 0 whenever no qualified read is in progress, and when address 2 is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| tx_idle | input | 1 | Transmit engine idle |
| tx_buf_empty | input | 1 | Transmit buffer empty flag |
| rx_idle | input | 1 | Receive engine idle |
| rx_buf_full | input | 1 | Receive buffer full flag |
| rx_frame_err | input | 1 | Receive frame error flag |
| rx_buf_data | input | 8 | Receive buffer contents |
| tx_buf_wr | output | 1 | One-cycle transmit buffer write enable |
| status_rd | output | 1 | One-cycle status read pulse |
| rx_buf_rd | output | 1 | One-cycle receive buffer read pulse |
| drv_en | output | 1 | Line driver enable, active high |
| rcv_en_n | output | 1 | Line receiver enable, active low |

## Verification
The bench holds strobes for several cycles. A design that fires enables on the level of a strobe, rather than on its leading edge, produces repeated buffer writes or repeated flag clears. The bench also requests a direction change while the owning engine is busy. A design that ignores the idle indication would turn the line around mid-frame, and the bench would see the enables drop early. Writes to the transmit buffer in receive mode, and strobes with chip select high, are used to expose designs that leak pulses or register updates. Status reads cycle through single-flag patterns, so any swapped bit position shows up as a data mismatch.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
   localparam int unsigned ADDR_W = 2;
   typedef enum logic [ADDR_W-1:0] {
      REG_DIR    = 2'd0,
      REG_STATUS = 2'd1,
      REG_TXBUF  = 2'd2,
      REG_RXBUF  = 2'd3
   } reg_sel_e;
   localparam int unsigned STAT_TX_EMPTY = 0;
   localparam int unsigned STAT_RX_FULL  = 1;
   localparam int unsigned STAT_FRM_ERR  = 2;
   localparam int unsigned STAT_BITS     = 3;
endpackage

// File: rtl/hdx_strobe_edge.sv
module hdx_strobe_edge #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] level,
   output logic [N-1:0] lead
);
   logic [N-1:0] prev;

   if (N < 1) begin : g_chk
      $error("hdx_strobe_edge: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_edge
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev[i] <= 1'b0;
         else        prev[i] <= level[i];
      end
      assign lead[i] = level[i] & ~prev[i];
   end
endmodule

// File: rtl/hdx_dir_ctrl.sv
module hdx_dir_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic want_tx,
   input  logic tx_idle,
   input  logic rx_idle,
   output logic tx_mode
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_mode <= 1'b1;
      end else if (tx_mode) begin
         if (!want_tx && tx_idle) tx_mode <= 1'b0;
      end else begin
         if (want_tx && rx_idle) tx_mode <= 1'b1;
      end
   end

   a_r3_hold_while_tx_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tx_mode) && !$past(tx_idle)) |-> tx_mode);
   a_r4_hold_while_rx_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(tx_mode) && !$past(rx_idle)) |-> !tx_mode);
endmodule

// File: rtl/hdx_link_ctrl.sv
module hdx_link_ctrl #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              tx_idle,
   input  logic              tx_buf_empty,
   input  logic              rx_idle,
   input  logic              rx_buf_full,
   input  logic              rx_frame_err,
   input  logic [DATA_W-1:0] rx_buf_data,
   output logic              tx_buf_wr,
   output logic              status_rd,
   output logic              rx_buf_rd,
   output logic              drv_en,
   output logic              rcv_en_n
);
   import hdx_pkg::*;

   localparam int unsigned PAD_W = DATA_W - STAT_BITS;

   if (DATA_W < STAT_BITS + 1) begin : g_chk
      $error("hdx_link_ctrl: DATA_W too small for status byte");
   end

   logic       wr_q, rd_q;
   logic [1:0] lead;
   logic       want_tx;
   logic       tx_mode;
   reg_sel_e   sel;

   assign sel  = reg_sel_e'(addr);
   assign wr_q = ~cs_n & ~wr_n;
   assign rd_q = ~cs_n & ~rd_n;

   hdx_strobe_edge #(.N(2)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level ({rd_q, wr_q}),
      .lead  (lead)
   );

   hdx_dir_ctrl u_dir (
      .clk     (clk),
      .rst_n   (rst_n),
      .want_tx (want_tx),
      .tx_idle (tx_idle),
      .rx_idle (rx_idle),
      .tx_mode (tx_mode)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         want_tx   <= 1'b1;
         tx_buf_wr <= 1'b0;
         status_rd <= 1'b0;
         rx_buf_rd <= 1'b0;
      end else begin
         if (lead[0] && sel == REG_DIR) want_tx <= wdata[0];
         tx_buf_wr <= lead[0] && sel == REG_TXBUF && tx_mode;
         status_rd <= lead[1] && sel == REG_STATUS;
         rx_buf_rd <= lead[1] && sel == REG_RXBUF;
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_q) begin
         unique case (sel)
            REG_DIR:    rdata[0] = want_tx;
            REG_STATUS: rdata = {{PAD_W{1'b0}}, rx_frame_err, rx_buf_full, tx_buf_empty};
            REG_TXBUF:  rdata = '0;
            REG_RXBUF:  rdata = rx_buf_data;
            default:    rdata = '0;
         endcase
      end
   end

   assign drv_en   = tx_mode;
   assign rcv_en_n = tx_mode;

   a_r8_tx_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
      tx_buf_wr |=> !tx_buf_wr);
   a_r9_no_tx_wr_in_rx: assert property (@(posedge clk) disable iff (!rst_n)
      tx_buf_wr |-> $past(drv_en));
   a_r6_status_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
      status_rd |=> !status_rd);
   a_r7_rx_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_buf_rd |=> !rx_buf_rd);
   a_r3_enter_rx_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drv_en) |-> ($past(tx_idle) && !$past(want_tx)));
   a_r4_enter_tx_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_en) |-> ($past(rx_idle) && $past(want_tx)));
   a_r10_no_pulse_unselected: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_n) |-> !(tx_buf_wr || status_rd || rx_buf_rd));
   a_r1_pins_paired: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en == rcv_en_n);
endmodule

// File: tb/hdx_link_ctrl_tb.sv
module hdx_link_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       tx_idle = 1'b1, tx_buf_empty = 1'b1;
   logic       rx_idle = 1'b1, rx_buf_full = 1'b0, rx_frame_err = 1'b0;
   logic [7:0] rx_buf_data = 8'h00;
   logic       tx_buf_wr, status_rd, rx_buf_rd, drv_en, rcv_en_n;

   int checks = 0, errors = 0;
   int n_txwr = 0, n_srd = 0, n_rrd = 0;

   // reference model state
   bit m_tx = 1, m_want = 1, m_pw = 0, m_pr = 0;
   bit m_txwr = 0, m_srd = 0, m_rrd = 0;

   always #10 clk = ~clk;

   hdx_link_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
      .addr(addr), .wdata(wdata), .rdata(rdata),
      .tx_idle(tx_idle), .tx_buf_empty(tx_buf_empty), .rx_idle(rx_idle),
      .rx_buf_full(rx_buf_full), .rx_frame_err(rx_frame_err),
      .rx_buf_data(rx_buf_data), .tx_buf_wr(tx_buf_wr), .status_rd(status_rd),
      .rx_buf_rd(rx_buf_rd), .drv_en(drv_en), .rcv_en_n(rcv_en_n)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference, advanced on the same edge as the design
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_tx = 1; m_want = 1; m_pw = 0; m_pr = 0;
         m_txwr = 0; m_srd = 0; m_rrd = 0;
      end else begin
         bit w, r, wl, rl, nxt_tx;
         w  = !cs_n && !wr_n;
         r  = !cs_n && !rd_n;
         wl = w && !m_pw;
         rl = r && !m_pr;
         nxt_tx = m_tx;
         if (m_tx && !m_want && tx_idle) nxt_tx = 0;
         if (!m_tx && m_want && rx_idle) nxt_tx = 1;
         m_txwr = wl && addr == 2 && m_tx;
         m_srd  = rl && addr == 1;
         m_rrd  = rl && addr == 3;
         if (wl && addr == 0) m_want = wdata[0];
         m_tx = nxt_tx;
         m_pw = w; m_pr = r;
      end
   end

   function automatic logic [7:0] exp_rdata();
      if (cs_n || rd_n) return 8'h00;
      case (addr)
         2'd0: return {7'd0, m_want};
         2'd1: return {5'd0, rx_frame_err, rx_buf_full, tx_buf_empty};
         2'd3: return rx_buf_data;
         default: return 8'h00;
      endcase
   endfunction

   // every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      check("R3_R4 drv_en", {7'd0, drv_en}, {7'd0, m_tx});
      check("R1 rcv_en_n", {7'd0, rcv_en_n}, {7'd0, m_tx});
      check("R8 tx_buf_wr", {7'd0, tx_buf_wr}, {7'd0, m_txwr});
      check("R6 status_rd", {7'd0, status_rd}, {7'd0, m_srd});
      check("R7 rx_buf_rd", {7'd0, rx_buf_rd}, {7'd0, m_rrd});
      check("R10 rdata", rdata, exp_rdata());
      n_txwr += int'(tx_buf_wr);
      n_srd  += int'(status_rd);
      n_rrd  += int'(rx_buf_rd);
   end

   task automatic idle_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input int hold, input bit sel);
      @(negedge clk); #1;
      cs_n = !sel; wr_n = 0; addr = a; wdata = d;
      repeat (hold) @(negedge clk);
      #1; cs_n = 1; wr_n = 1;
   endtask

   task automatic bus_read(input logic [1:0] a, input int hold, input bit sel, output logic [7:0] got);
      @(negedge clk); #1;
      cs_n = !sel; rd_n = 0; addr = a;
      @(negedge clk); got = rdata;
      repeat (hold - 1) @(negedge clk);
      #1; cs_n = 1; rd_n = 1;
   endtask

   initial begin
      logic [7:0] v;
      int base;
      idle_cycles(2);
      check("R1 reset drv_en", {7'd0, drv_en}, 8'd1);
      check("R1 reset rcv_en_n", {7'd0, rcv_en_n}, 8'd1);
      check("R1 reset pulses", {5'd0, tx_buf_wr, status_rd, rx_buf_rd}, 8'd0);
      #1 rst_n = 1;
      idle_cycles(2);

      bus_write(2'd0, 8'hFF, 1, 1);
      bus_read(2'd0, 1, 1, v);
      check("R2 dir readback", v, 8'h01);

      base = n_txwr;
      bus_write(2'd2, 8'h5A, 4, 1);
      idle_cycles(2);
      check("R8 held write single pulse", 8'(n_txwr - base), 8'd1);

      tx_idle = 0;
      bus_write(2'd0, 8'hFE, 1, 1);
      idle_cycles(4);
      check("R3 hold while tx busy", {7'd0, drv_en}, 8'd1);
      tx_idle = 1;
      idle_cycles(2);
      check("R3 switched to rx", {6'd0, drv_en, rcv_en_n}, 8'd0);

      base = n_txwr;
      bus_write(2'd2, 8'h33, 2, 1);
      idle_cycles(2);
      check("R9 tx write ignored in rx", 8'(n_txwr - base), 8'd0);

      rx_idle = 0;
      bus_write(2'd0, 8'h01, 1, 1);
      idle_cycles(4);
      check("R4 hold while rx busy", {7'd0, drv_en}, 8'd0);
      rx_idle = 1;
      idle_cycles(2);
      check("R4 switched to tx", {6'd0, drv_en, rcv_en_n}, 8'h03);

      for (int i = 0; i < 4; i++) begin
         tx_buf_empty = (i == 1); rx_buf_full = (i == 2); rx_frame_err = (i == 3);
         base = n_srd;
         bus_read(2'd1, 3, 1, v);
         check("R5 status byte", v, (i == 0) ? 8'h00 : 8'(1 << (i - 1)));
         idle_cycles(1);
         check("R6 status pulse count", 8'(n_srd - base), 8'd1);
      end

      rx_buf_data = 8'hC3;
      base = n_rrd;
      bus_read(2'd3, 3, 1, v);
      idle_cycles(1);
      check("R7 rx data", v, 8'hC3);
      check("R7 rx pulse count", 8'(n_rrd - base), 8'd1);

      base = n_txwr + n_srd + n_rrd;
      bus_write(2'd0, 8'h00, 2, 0);
      bus_write(2'd2, 8'h11, 2, 0);
      bus_read(2'd1, 2, 0, v);
      check("R10 unselected rdata", v, 8'h00);
      bus_read(2'd3, 2, 0, v);
      idle_cycles(3);
      check("R10 no pulses", 8'(n_txwr + n_srd + n_rrd - base), 8'd0);
      check("R10 mode kept", {7'd0, drv_en}, 8'd1);
      bus_read(2'd0, 1, 1, v);
      check("R10 dir kept", v, 8'h01);
      bus_read(2'd2, 1, 1, v);
      check("R10 txbuf reads zero", v, 8'h00);

      idle_cycles(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2_000_000;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule